// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block keeps a time-of-day count in nanoseconds for precision time protocol use. On every cycle of its reference clock it adds a programmable rate word to an accumulator. The rate word is a nanosecond value in fixed point, with 4 integer bits and 28 fraction bits, so the nominal word 0x80000000 advances the count by 8 ns per cycle of a 125 MHz clock. Software trims the frequency by moving the rate word up or down from that value. One part per billion is roughly 2^28 / 125e6 LSBs, or about 2.15 LSBs. Software can also freeze the count by writing a rate of zero.

The 44-bit integer count is reached through a small bus with four 32-bit words. The count is split into a 4-bit low nibble, a 32-bit middle word and an 8-bit top byte. The top byte is written from data bits [15:8] but read back on bits [7:0]. Software loads or steps the time by writing these fields, and reads them back one cycle after it presents an address.

Top module: `nco_time_counter`

## Requirements
- R1: After reset the count, its 28 fraction bits and the rate word are all zero, every read returns 0, and the count does not advance.
- R2: On each clock edge with no time-field write, the accumulator (44 integer bits above 28 fraction bits) grows by the rate word, with the rate word aligned to the lowest fraction bit; the rate word 0x80000000 gives 8 ns per cycle.
- R3: A rate word of zero holds the count unchanged; a write to the rate word is used by the addition from the following edge onward.
- R4: Fraction bits accumulate across cycles, and carries ripple from the fraction into the low nibble, from the low nibble into the middle word, and from the middle word into the top byte.
- R5: The integer count wraps modulo 2^44: from 0xFFFFFFFFFFF one more nanosecond gives zero.
- R6: Word index 0 is the low nibble (read on bits [3:0], upper bits zero), index 1 is count bits [35:4], index 2 is the top byte (count bits [43:36]), and index 3 is the rate word.
- R7: A write to index 2 takes the top byte from data bits [15:8] and ignores all other data bits. A read of index 2 returns the top byte on bits [7:0] with the upper bits zero.
- R8: A write to index 0 loads count bits [3:0] from data bits [3:0], clears all fraction bits and ignores data bits [31:4].
- R9: When a time field is written on an edge where the count is also advancing, the written field takes the write data and the other fields take the advanced value.
- R10: A read gives bus_rvalid high and the addressed word on bus_rdata one cycle after the request, showing the state from before that edge's update; bus_rvalid is low in every other cycle.
- R11: The rate word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the count advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (0 low nibble, 1 middle, 2 top, 3 rate) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench loads the count with all ones and advances it, so that a carry has to cross every field boundary and the count has to wrap. A break in the carry chain would leave a field stale, and a wrong width would wrap at the wrong point. It stops the count after a known number of cycles with a fractional rate, which shows whether the fraction survives between cycles and whether a write to the low nibble clears it: a stale fraction produces one extra nanosecond. It writes the middle word while the count runs, which catches a design that gives the addition priority or that freezes the other fields on a write. It writes the top byte with data on every lane, which catches a design that takes the byte from the wrong bits.

// File: rtl/nco_time_pkg.sv
package nco_time_pkg;
  localparam int INT_W      = 44;
  localparam int FRAC_W     = 28;
  localparam int ACC_W      = INT_W + FRAC_W;
  localparam int DATA_W     = 32;
  localparam int LOW_W      = 4;
  localparam int MID_W      = 32;
  localparam int TOP_W      = INT_W - LOW_W - MID_W;
  localparam int TOP_WR_LSB = 8;
  localparam int SEL_W      = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LOW  = 2'd0,
    SEL_MID  = 2'd1,
    SEL_TOP  = 2'd2,
    SEL_RATE = 2'd3
  } field_sel_e;

  // Adds the rate word, aligned to the lowest fraction bit, to the accumulator.
  // The result carries one extra bit that marks a wrap of the whole count.
  function automatic logic [ACC_W:0] acc_advance(input logic [ACC_W-1:0] acc,
                                                 input logic [DATA_W-1:0] rate);
    return {1'b0, acc} + {{(ACC_W+1-DATA_W){1'b0}}, rate};
  endfunction

  // Builds the read word for one field of the integer count.
  function automatic logic [DATA_W-1:0] field_word(input logic [INT_W-1:0] cnt,
                                                   input logic [DATA_W-1:0] rate,
                                                   input field_sel_e sel);
    case (sel)
      SEL_LOW: return {{(DATA_W-LOW_W){1'b0}}, cnt[LOW_W-1:0]};
      SEL_MID: return cnt[LOW_W +: MID_W];
      SEL_TOP: return {{(DATA_W-TOP_W){1'b0}}, cnt[INT_W-1 -: TOP_W]};
      default: return rate;
    endcase
  endfunction
endpackage

// File: rtl/nco_bus_decode.sv
module nco_bus_decode
  import nco_time_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [INT_W-1:0]  cnt_int,
  input  logic [DATA_W-1:0] rate_q,
  output logic              wr_low,
  output logic              wr_mid,
  output logic              wr_top,
  output logic              wr_rate,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  field_sel_e sel;
  logic       rd_req;

  assign sel     = field_sel_e'(bus_addr);
  assign rd_req  = bus_valid && !bus_wr;
  assign wr_low  = bus_valid && bus_wr && (sel == SEL_LOW);
  assign wr_mid  = bus_valid && bus_wr && (sel == SEL_MID);
  assign wr_top  = bus_valid && bus_wr && (sel == SEL_TOP);
  assign wr_rate = bus_valid && bus_wr && (sel == SEL_RATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= field_word(cnt_int, rate_q, sel);
    end
  end

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rvalid == $past(rd_req)));

  // R6
  one_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_low, wr_mid, wr_top, wr_rate}));
endmodule

// File: rtl/nco_rate_reg.sv
module nco_rate_reg
  import nco_time_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rate,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (wr_rate) rate_q <= wdata;
  end

  // R11
  rate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rate |=> (rate_q == $past(wdata)));
endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_time_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rate_q,
  input  logic              wr_low,
  input  logic              wr_mid,
  input  logic              wr_top,
  input  logic [DATA_W-1:0] wdata,
  output logic [INT_W-1:0]  cnt_int
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W:0]   sum_ext;
  logic             any_time_wr;
  logic             wrap_evt;
  logic             freeze_evt;

  assign sum_ext     = acc_advance(acc_q, rate_q);
  assign any_time_wr = wr_low || wr_mid || wr_top;
  assign wrap_evt    = sum_ext[ACC_W] && !any_time_wr;
  assign freeze_evt  = (rate_q == '0) && !any_time_wr;

  always_comb begin
    acc_nxt = sum_ext[ACC_W-1:0];
    if (wr_low) acc_nxt[FRAC_W+LOW_W-1:0]      = {wdata[LOW_W-1:0], {FRAC_W{1'b0}}};
    if (wr_mid) acc_nxt[FRAC_W+LOW_W +: MID_W] = wdata[MID_W-1:0];
    if (wr_top) acc_nxt[ACC_W-1 -: TOP_W]      = wdata[TOP_WR_LSB +: TOP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  assign cnt_int = acc_q[ACC_W-1:FRAC_W];

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> $stable(acc_q));

  // R5
  wrap_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (acc_q[ACC_W-1 -: TOP_W] == '0));

  // R7
  top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top |=> (acc_q[ACC_W-1 -: TOP_W] == $past(wdata[TOP_WR_LSB +: TOP_W])));

  // R8
  low_clears_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> (acc_q[FRAC_W-1:0] == '0));
endmodule

// File: rtl/nco_time_counter.sv
module nco_time_counter
  import nco_time_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic              wr_low, wr_mid, wr_top, wr_rate;
  logic [DATA_W-1:0] rate_q;
  logic [INT_W-1:0]  cnt_int;

  nco_bus_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cnt_int   (cnt_int),
    .rate_q    (rate_q),
    .wr_low    (wr_low),
    .wr_mid    (wr_mid),
    .wr_top    (wr_top),
    .wr_rate   (wr_rate),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  nco_rate_reg u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_rate (wr_rate),
    .wdata   (bus_wdata),
    .rate_q  (rate_q)
  );

  nco_accum u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_q  (rate_q),
    .wr_low  (wr_low),
    .wr_mid  (wr_mid),
    .wr_top  (wr_top),
    .wdata   (bus_wdata),
    .cnt_int (cnt_int)
  );
endmodule

// File: tb/tb_nco_time_counter.sv
module tb_nco_time_counter;
  localparam logic [1:0] A_LOW = 2'd0, A_MID = 2'd1, A_TOP = 2'd2, A_RATE = 2'd3;
  localparam logic [31:0] NS1 = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  nco_time_counter dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  // Called at a falling edge; the write is taken at the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    n_chk++;
    if (!bus_rvalid || bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s word %0d: got %h (rvalid %b) expected %h", req, a, bus_rdata, bus_rvalid, exp);
    end
  endtask

  task automatic load(input logic [3:0] lo, input logic [31:0] mid, input logic [7:0] top);
    wr(A_MID, mid);
    wr(A_TOP, {16'h0, top, 8'h0});
    wr(A_LOW, {28'h0, lo});
  endtask

  // Runs the count for (gap + 1) additions at rate r, then stops it.
  task automatic run(input logic [31:0] r, input int gap);
    wr(A_RATE, r);
    repeat (gap) @(negedge clk);
    wr(A_RATE, 32'h0);
  endtask

  task automatic t_reset;
    rd_chk(A_LOW, 32'h0, "R1");
    rd_chk(A_MID, 32'h0, "R1");
    rd_chk(A_TOP, 32'h0, "R1");
    rd_chk(A_RATE, 32'h0, "R1");
    repeat (20) @(negedge clk);
    rd_chk(A_LOW, 32'h0, "R1 idle");
  endtask

  task automatic t_fields;
    wr(A_LOW, 32'hFFFF_FFF3);
    rd_chk(A_LOW, 32'h3, "R8 low nibble only");
    wr(A_MID, 32'h1234_5678);
    rd_chk(A_MID, 32'h1234_5678, "R6 middle word");
    wr(A_TOP, 32'hFFFF_A5FF);
    rd_chk(A_TOP, 32'h0000_00A5, "R7 top lane");
    rd_chk(A_MID, 32'h1234_5678, "R7 middle untouched");
  endtask

  task automatic t_nominal;
    load(4'h0, 32'h0, 8'h0);
    run(32'h8000_0000, 99);   // 100 additions of 8 ns = 800 = 0x320
    rd_chk(A_LOW, 32'h0, "R2 nominal low");
    rd_chk(A_MID, 32'h32, "R2 nominal mid");
    rd_chk(A_TOP, 32'h0, "R2 nominal top");
  endtask

  task automatic t_fraction;
    load(4'h0, 32'h0, 8'h0);
    run(32'h1800_0000, 2);    // 3 x 1.5 ns = 4.5 ns
    rd_chk(A_LOW, 32'h4, "R4 fractional sum");
    wr(A_LOW, 32'h0);          // drops the pending 0.5 ns
    run(32'h0800_0000, 0);    // 0.5 ns
    rd_chk(A_LOW, 32'h0, "R8 fraction cleared");
    run(32'h0800_0000, 0);    // 1.0 ns
    rd_chk(A_LOW, 32'h1, "R4 half plus half");
    repeat (40) @(negedge clk);
    rd_chk(A_LOW, 32'h1, "R3 frozen at zero rate");
  endtask

  task automatic t_carry;
    load(4'hF, 32'hFFFF_FFFF, 8'h7F);
    run(NS1, 0);
    rd_chk(A_LOW, 32'h0, "R4 carry low");
    rd_chk(A_MID, 32'h0, "R4 carry mid");
    rd_chk(A_TOP, 32'h80, "R4 carry into top");
  endtask

  task automatic t_wrap;
    load(4'hF, 32'hFFFF_FFFF, 8'hFF);
    run(NS1, 2);               // max + 3 ns wraps to 2
    rd_chk(A_LOW, 32'h2, "R5 wrap low");
    rd_chk(A_MID, 32'h0, "R5 wrap mid");
    rd_chk(A_TOP, 32'h0, "R5 wrap top");
  endtask

  task automatic t_priority;
    load(4'h5, 32'h0, 8'h0);
    wr(A_RATE, NS1);           // additions from the next edge
    wr(A_MID, 32'h100);        // low still advances on this edge
    wr(A_RATE, 32'h0);         // one more addition
    rd_chk(A_LOW, 32'h7, "R9 low advanced");
    rd_chk(A_MID, 32'h100, "R9 middle written");
  endtask

  task automatic t_rate_and_read;
    wr(A_RATE, 32'h8000_00D7);
    rd_chk(A_RATE, 32'h8000_00D7, "R11 rate readback");
    wr(A_RATE, 32'h0);
    n_chk++;
    if (bus_rvalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 rvalid after write: got %b expected 0", bus_rvalid);
    end
    load(4'h9, 32'h0, 8'h0);
    rd_chk(A_LOW, 32'h9, "R10 read data");
    @(negedge clk);
    n_chk++;
    if (bus_rvalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 rvalid idle: got %b expected 0", bus_rvalid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_nominal();
    t_fraction();
    t_carry();
    t_wrap();
    t_priority();
    t_rate_and_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule